// File: doc/BRIEF.md
# Processor Status Word Register

This block keeps the condition flags that an arithmetic unit leaves behind, together with two control bits that steer the processor: an interrupt-enable bit and a supervisor-mode bit. Whenever the execution stage raises its update strobe, the register takes the result of the operation and the carry, overflow and compare indications that came with it. It then captures five flags: zero, sign, carry, equal and overflow. Programs never write these flags directly. They only consume them through the branch-condition outputs, which the sequencer reads for jump-if-zero style decisions.

The two control bits change only through a privileged write port. Such a write takes effect only while the supervisor bit is already set. Once software drops to user mode by clearing that bit, no write through this port can raise it again. Only reset can do that; the block includes no trap or interrupt entry path that would set it.

The whole state comes out as one packed status word. The interrupt-enable and supervisor bits are also available on their own pins for the interrupt controller and the protection logic.

Top module: `psw_reg`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the status word is 7'h40: supervisor set, everything else clear.
- R2: On a clock edge with upd_en high, the zero flag becomes 1 exactly when alu_result is all zeros.
- R3: On a clock edge with upd_en high, the sign flag takes the most significant bit of alu_result.
- R4: On a clock edge with upd_en high, the carry flag takes alu_carry and the overflow flag takes alu_ovf.
- R5: The equal flag loads cmp_eq only on an update with cmp_op high. On an update with cmp_op low it keeps its previous value.
- R6: While upd_en is low, the zero, sign, carry, equal and overflow flags keep their values, whatever the ALU inputs do.
- R7: A privileged write (priv_wr high) made while the supervisor bit is 1 loads priv_ie into the interrupt-enable bit and priv_sup into the supervisor bit.
- R8: A privileged write made while the supervisor bit is 0 is ignored. Both control bits keep their values, so user mode cannot re-enter supervisor mode.
- R9: The branch helpers follow the stored flags: br_zero = Z, br_nonzero = not Z, br_le_zero = Z or S, br_gt_zero = not Z and not S.
- R10: The status word layout is bit 0 zero, bit 1 sign, bit 2 carry, bit 3 equal, bit 4 overflow, bit 5 interrupt enable, bit 6 supervisor. irq_enable and supervisor mirror bits 5 and 6.
- R11: A flag update and a permitted privileged write in the same cycle both take effect. Neither blocks the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_en | input | 1 | Flag update strobe from the execution stage |
| alu_result | input | DATA_W | Result of the operation |
| alu_carry | input | 1 | Carry or borrow out of the operation |
| alu_ovf | input | 1 | Signed overflow of the operation |
| cmp_op | input | 1 | The operation is a compare; the equal flag is loaded |
| cmp_eq | input | 1 | Compare found its operands equal |
| priv_wr | input | 1 | Privileged write of the control bits |
| priv_ie | input | 1 | Interrupt-enable value for a privileged write |
| priv_sup | input | 1 | Supervisor value for a privileged write |
| status_word | output | 7 | Packed status word |
| irq_enable | output | 1 | Interrupt-enable bit |
| supervisor | output | 1 | Supervisor-mode bit |
| br_zero | output | 1 | Branch condition: result was zero |
| br_nonzero | output | 1 | Branch condition: result was not zero |
| br_le_zero | output | 1 | Branch condition: result less than or equal to zero |
| br_gt_zero | output | 1 | Branch condition: result greater than zero |

## Verification
The hardest case to reach from the ports is the lock-out. A privileged write must be refused after the supervisor bit has been cleared, and the refusal has to be seen on a word whose interrupt-enable bit differs from the attempted value. Otherwise an ignored write and an accepted write look the same at the ports. The stimulus therefore first sets interrupt enable while still privileged, then clears supervisor, then attempts a write that would flip both bits. After that it pulses reset to confirm that reset is the only way back. The equal flag's hold-on-non-compare behaviour is covered by an exhaustive sweep of result and indication values in which compare and non-compare updates alternate, so the held value is always a real earlier capture.

// File: rtl/psw_pkg.sv
// Package: shared bit positions and the packed status word type.
// Assumes a 7-bit word; the positions are decoded by the branch logic
// and by software, so they must not move.
package psw_pkg;
    localparam int PSW_W   = 7;
    localparam int FLAG_W  = 5;
    localparam int POS_Z   = 0;
    localparam int POS_S   = 1;
    localparam int POS_C   = 2;
    localparam int POS_E   = 3;
    localparam int POS_V   = 4;
    localparam int POS_IE  = 5;
    localparam int POS_SUP = 6;

    typedef struct packed {
        logic sup;
        logic ie;
        logic v;
        logic e;
        logic c;
        logic s;
        logic z;
    } psw_t;

    localparam psw_t PSW_RESET = '{sup: 1'b1, default: 1'b0};
endpackage

// File: rtl/psw_flag_gen.sv
// psw_flag_gen: computes the next condition flags from the current ones
// and the execution-stage indications. Purely combinational.
// Assumes DATA_W >= 2 and that cur_flags uses the package bit order.
module psw_flag_gen #(
    parameter int DATA_W = 16
) (
    input  logic                        upd_en,
    input  logic [DATA_W-1:0]           alu_result,
    input  logic                        alu_carry,
    input  logic                        alu_ovf,
    input  logic                        cmp_op,
    input  logic                        cmp_eq,
    input  logic [psw_pkg::FLAG_W-1:0]  cur_flags,
    output logic [psw_pkg::FLAG_W-1:0]  nxt_flags
);
    import psw_pkg::*;

    localparam int SIGN_POS = DATA_W - 1;

    logic res_zero;

    // Zero detection over the full result width.
    always_comb begin
        res_zero = (alu_result == '0);
    end

    // Select captured or held value for each flag.
    always_comb begin
        nxt_flags = cur_flags;
        if (upd_en) begin
            nxt_flags[POS_Z] = res_zero;
            nxt_flags[POS_S] = alu_result[SIGN_POS];
            nxt_flags[POS_C] = alu_carry;
            nxt_flags[POS_V] = alu_ovf;
            if (cmp_op) begin
                nxt_flags[POS_E] = cmp_eq;
            end
        end
    end
endmodule

// File: rtl/psw_ctrl_bits.sv
// psw_ctrl_bits: interrupt-enable and supervisor bits behind a privilege
// gate. A write is accepted only while the stored supervisor bit is 1.
// Assumes the synchronous active-low reset of the surrounding block.
module psw_ctrl_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic priv_wr,
    input  logic priv_ie,
    input  logic priv_sup,
    output logic ie_q,
    output logic sup_q
);
    logic wr_ok;

    // Gate the write with the current privilege level.
    always_comb begin
        wr_ok = priv_wr & sup_q;
    end

    // Hold the control bits; reset enters supervisor mode with interrupts off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q  <= 1'b0;
            sup_q <= 1'b1;
        end else if (wr_ok) begin
            ie_q  <= priv_ie;
            sup_q <= priv_sup;
        end
    end

    AST_PRIV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_wr && sup_q) |=> (ie_q == $past(priv_ie)) && (sup_q == $past(priv_sup))); // R7

    AST_USER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!sup_q) |=> ($stable(ie_q) && !sup_q)); // R8
endmodule

// File: rtl/psw_branch_cond.sv
// psw_branch_cond: derives the branch-condition helpers from the stored
// zero and sign flags. Combinational, no state.
module psw_branch_cond (
    input  logic flag_z,
    input  logic flag_s,
    output logic br_zero,
    output logic br_nonzero,
    output logic br_le_zero,
    output logic br_gt_zero
);
    // Map the flags onto the four tests offered to the sequencer.
    always_comb begin
        br_zero    = flag_z;
        br_nonzero = ~flag_z;
        br_le_zero = flag_z | flag_s;
        br_gt_zero = ~(flag_z | flag_s);
    end
endmodule

// File: rtl/psw_reg.sv
// psw_reg: processor status word. Registers the five condition flags on
// each update strobe, holds the privileged control bits and drives the
// packed word and branch helpers. Assumes synchronous active-low reset.
module psw_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_carry,
    input  logic              alu_ovf,
    input  logic              cmp_op,
    input  logic              cmp_eq,
    input  logic              priv_wr,
    input  logic              priv_ie,
    input  logic              priv_sup,
    output logic [6:0]        status_word,
    output logic              irq_enable,
    output logic              supervisor,
    output logic              br_zero,
    output logic              br_nonzero,
    output logic              br_le_zero,
    output logic              br_gt_zero
);
    import psw_pkg::*;

    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] flags_d;
    logic              ie_q;
    logic              sup_q;
    psw_t              word;

    psw_flag_gen #(
        .DATA_W(DATA_W)
    ) u_flag_gen (
        .upd_en    (upd_en),
        .alu_result(alu_result),
        .alu_carry (alu_carry),
        .alu_ovf   (alu_ovf),
        .cmp_op    (cmp_op),
        .cmp_eq    (cmp_eq),
        .cur_flags (flags_q),
        .nxt_flags (flags_d)
    );

    // Condition flag storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    psw_ctrl_bits u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .priv_wr (priv_wr),
        .priv_ie (priv_ie),
        .priv_sup(priv_sup),
        .ie_q    (ie_q),
        .sup_q   (sup_q)
    );

    psw_branch_cond u_branch (
        .flag_z    (flags_q[POS_Z]),
        .flag_s    (flags_q[POS_S]),
        .br_zero   (br_zero),
        .br_nonzero(br_nonzero),
        .br_le_zero(br_le_zero),
        .br_gt_zero(br_gt_zero)
    );

    // Pack the word in the fixed bit order.
    always_comb begin
        word.z   = flags_q[POS_Z];
        word.s   = flags_q[POS_S];
        word.c   = flags_q[POS_C];
        word.e   = flags_q[POS_E];
        word.v   = flags_q[POS_V];
        word.ie  = ie_q;
        word.sup = sup_q;
    end

    assign status_word = word;
    assign irq_enable  = ie_q;
    assign supervisor  = sup_q;

    AST_ZERO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (br_zero == ($past(alu_result) == '0))); // R2

    AST_SIGN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (status_word[1] == $past(alu_result[DATA_W-1]))); // R3

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(status_word[4:0])); // R6

    AST_EQUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !cmp_op) |=> $stable(status_word[3])); // R5

    AST_GT_EXCLUDES_LE: assert property (@(posedge clk) disable iff (!rst_n)
        br_gt_zero |-> (!status_word[0] && !status_word[1] && !br_le_zero)); // R9
endmodule

// File: tb/tb_psw_reg.sv
// tb_psw_reg: exhaustive sweep of a 4-bit configuration with an
// arithmetic reference model of the status word.
module tb_psw_reg;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          upd_en = 1'b0;
    logic [DW-1:0] alu_result = '0;
    logic          alu_carry = 1'b0;
    logic          alu_ovf = 1'b0;
    logic          cmp_op = 1'b0;
    logic          cmp_eq = 1'b0;
    logic          priv_wr = 1'b0;
    logic          priv_ie = 1'b0;
    logic          priv_sup = 1'b0;
    logic [6:0]    status_word;
    logic          irq_enable;
    logic          supervisor;
    logic          br_zero;
    logic          br_nonzero;
    logic          br_le_zero;
    logic          br_gt_zero;

    int   n_checks = 0;
    int   n_fails = 0;
    logic done = 1'b0;
    logic [6:0] exp_w;

    psw_reg #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .alu_result(alu_result),
        .alu_carry(alu_carry), .alu_ovf(alu_ovf), .cmp_op(cmp_op),
        .cmp_eq(cmp_eq), .priv_wr(priv_wr), .priv_ie(priv_ie),
        .priv_sup(priv_sup), .status_word(status_word),
        .irq_enable(irq_enable), .supervisor(supervisor),
        .br_zero(br_zero), .br_nonzero(br_nonzero),
        .br_le_zero(br_le_zero), .br_gt_zero(br_gt_zero)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Compare every output against the model word.
    task automatic check_all();
        chk("R2 zero flag", 7'(status_word[0]), 7'(exp_w[0]));
        chk("R3 sign flag", 7'(status_word[1]), 7'(exp_w[1]));
        chk("R4 carry/overflow", 7'({status_word[4], status_word[2]}), 7'({exp_w[4], exp_w[2]}));
        chk("R5 equal flag", 7'(status_word[3]), 7'(exp_w[3]));
        chk("R10 whole word", status_word, exp_w);
        chk("R10 mirror pins", 7'({supervisor, irq_enable}), 7'(exp_w[6:5]));
        chk("R9 branch helpers",
            7'({br_zero, br_nonzero, br_le_zero, br_gt_zero}),
            7'({exp_w[0], !exp_w[0], exp_w[0] | exp_w[1], !(exp_w[0] | exp_w[1])}));
    endtask

    // Drive one cycle from a negedge, update the model, sample at the next negedge.
    task automatic step(input logic u, input logic [DW-1:0] r, input logic c,
                        input logic v, input logic cm, input logic eq,
                        input logic w, input logic wie, input logic wsup);
        logic [6:0] nx;
        upd_en = u; alu_result = r; alu_carry = c; alu_ovf = v;
        cmp_op = cm; cmp_eq = eq; priv_wr = w; priv_ie = wie; priv_sup = wsup;
        nx = exp_w;
        if (u) begin
            nx[0] = (r == 0);
            nx[1] = r[DW-1];
            nx[2] = c;
            nx[4] = v;
            if (cm) nx[3] = eq;
        end
        if (w && exp_w[6]) begin
            nx[5] = wie;
            nx[6] = wsup;
        end
        @(posedge clk);
        @(negedge clk);
        exp_w = nx;
        priv_wr = 1'b0;
        upd_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        exp_w = 7'h40;
        chk("R1 reset value", status_word, 7'h40);
        rst_n = 1'b1;
    endtask

    initial begin
        exp_w = 7'h40;
        @(negedge clk);
        do_reset();
        check_all();

        // R2 R3 R4 R5 R6 R9: every result with every indication set, update on and off.
        for (int u = 0; u < 2; u++) begin
            for (int r = 0; r < 16; r++) begin
                for (int f = 0; f < 16; f++) begin
                    step(u[0] ^ f[0], DW'(r), f[0], f[1], f[2], f[3], 1'b0, 1'b0, 1'b0);
                    check_all();
                end
            end
        end

        // R6: flags frozen while inputs churn with the strobe low.
        step(1'b1, 4'h9, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int r = 0; r < 16; r++) begin
            step(1'b0, DW'(r), r[0], r[1], 1'b1, r[2], 1'b0, 1'b0, 1'b0);
            chk("R6 flags hold", 7'(status_word[4:0]), 7'(exp_w[4:0]));
        end

        // R7: privileged write in supervisor mode sets interrupt enable.
        step(1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        chk("R7 privileged load", 7'(status_word[6:5]), 7'b11);

        // R11: update and privileged write in the same cycle.
        step(1'b1, 4'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        chk("R11 combined update", status_word, 7'h5D);
        check_all();

        // R7: leave supervisor mode with interrupts enabled.
        step(1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R7 drop to user", 7'(status_word[6:5]), 7'b01);

        // R8: attempts to flip both bits from user mode are refused.
        step(1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R8 user write ignored", 7'(status_word[6:5]), 7'b01);
        step(1'b1, 4'h7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R8 user write ignored with update", 7'(status_word[6:5]), 7'b01);
        check_all();

        // R1: only reset restores supervisor mode.
        @(negedge clk);
        do_reset();
        check_all();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule